// File: doc/BRIEF.md
# Gray-Coded Hit Latency Delay Unit

This block holds a discriminator hit for a programmable trigger latency without passing the hit down a long shift chain. A shared timestamp generator runs an up-down counter that turns at a programmable modulus n. It puts the Gray-coded counter value on an 8-bit bus. When a hit arrives, a free delay unit stores the bus value. The unit then compares its stored value with the live bus on every clock and counts the matches. The capture itself counts as the first match. The counter visits each value twice per period of 2n+2 clocks, so the third match comes exactly 2n+2 clocks after the capture. At that point the unit raises a one-cycle expiry pulse and frees itself.

Each pixel has two delay units, so two hits can wait at the same time. A new hit goes to unit 0 if unit 0 is free, otherwise to unit 1. A hit that arrives while both units are occupied is lost and sets a sticky overflow flag. A mask input makes the pixel ignore hits. The modulus must stay constant except while reset is held.

Top module: `gray_hit_delay`

## Requirements
- R1: While `rst` is sampled high on a rising edge, from the next cycle on `expired` is 0, `busy` is 0, `overflow` is 0 and the timestamp counter restarts at 0 counting upward.
- R2: A hit accepted on rising edge E causes `expired[u]` of the unit that took it to be 1 during the cycle after edge E+2n+2, for every n from 0 to 255. Bit u of `expired` is unit u.
- R3: Each expiry is a single-cycle pulse. The unit becomes free at the edge where the pulse starts, and it can accept a hit on the next edge. A hit that arrives on the expiry edge itself still sees that unit as occupied.
- R4: An accepted hit goes to unit 0 when unit 0 is free, and to unit 1 only when unit 0 is occupied.
- R5: Two hits can be held at the same time. Each expires at its own 2n+2 latency without disturbing the other.
- R6: A hit (with `mask` low) sampled while both units are occupied changes neither unit and produces no expiry. It sets `overflow` one cycle later, and `overflow` stays 1 until reset.
- R7: A hit sampled with `mask` high occupies no unit, produces no expiry and does not set `overflow`.
- R8: `busy` is 1 exactly while both units are occupied, that is, while a new hit would be lost. It is a registered output and changes in the cycle after the edge that fills or frees a unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | 1 | Discriminator hit, sampled on each rising edge |
| mask | input | 1 | When 1, hits are ignored |
| modulus | input | 8 | Turning point n of the timestamp counter; changed only under reset |
| expired | output | 2 | One-cycle expiry pulse per delay unit (bit u is unit u) |
| busy | output | 1 | Both delay units occupied |
| overflow | output | 1 | Sticky: a hit was lost because both units were occupied |

## Verification
Suppose a hit is sampled on edge E. Its expiry is due in the cycle after edge E+2n+2. Any change to `busy` or `overflow` is due in the cycle after E itself. The bench changes inputs only on falling edges. Its reference model keeps a countdown per unit and advances it once per rising edge, so every expected value belongs to one specific edge. Outputs are compared at the next falling edge, and every cycle is checked. This covers the expiry edge, where a second hit must still see the unit as occupied. It also covers the edge right after, where the freed unit must take the hit again.

// File: rtl/ghd_pkg.sv
package ghd_pkg;
  // number of delay units per pixel
  localparam int DU_COUNT = 2;
  // width of the per-unit match counter
  localparam int MATCH_W = 2;
  // count value that, with a further equality, completes the latency
  localparam int LAST_MATCH = 2;

  typedef struct packed {
    logic [DU_COUNT-1:0] load;   // capture the bus, start counting
    logic [DU_COUNT-1:0] step;   // one more match seen
    logic [DU_COUNT-1:0] clear;  // latency elapsed, release unit
  } du_strobe_t;
endpackage

// File: rtl/ghd_stamp_path.sv
module ghd_stamp_path import ghd_pkg::*; #(
  parameter int STAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STAMP_W-1:0] modulus,
  input  du_strobe_t         strobe,
  output logic [DU_COUNT-1:0] stampEq,
  output logic [DU_COUNT-1:0] lastMatch
);
  logic [STAMP_W-1:0] tick;
  logic               goingUp;
  logic [STAMP_W-1:0] stampBus;

  // up-down counter: 0,1..n,n,n-1..0,0,1.. (dwells once at each end)
  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      goingUp <= 1'b1;
    end else if (goingUp) begin
      if (tick >= modulus) goingUp <= 1'b0;
      else                 tick    <= tick + 1'b1;
    end else begin
      if (tick == '0) goingUp <= 1'b1;
      else            tick    <= tick - 1'b1;
    end
  end

  assign stampBus = tick ^ (tick >> 1);

  for (genvar u = 0; u < DU_COUNT; u++) begin : g_unit
    logic [STAMP_W-1:0] heldStamp;
    logic [MATCH_W-1:0] matchCnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        heldStamp <= '0;
        matchCnt  <= '0;
      end else if (strobe.load[u]) begin
        heldStamp <= stampBus;
        matchCnt  <= MATCH_W'(1);
      end else if (strobe.clear[u]) begin
        matchCnt  <= '0;
      end else if (strobe.step[u]) begin
        matchCnt  <= matchCnt + 1'b1;
      end
    end

    assign stampEq[u]   = (heldStamp == stampBus);
    assign lastMatch[u] = stampEq[u] && (matchCnt == MATCH_W'(LAST_MATCH));
  end
endmodule

// File: rtl/ghd_unit_ctrl.sv
module ghd_unit_ctrl import ghd_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic                mask,
  input  logic [DU_COUNT-1:0] stampEq,
  input  logic [DU_COUNT-1:0] lastMatch,
  output du_strobe_t          strobe,
  output logic [DU_COUNT-1:0] expired,
  output logic                busy,
  output logic                overflow
);
  logic [DU_COUNT-1:0] unitBusy;
  logic [DU_COUNT-1:0] grant;
  logic                accept;
  logic                dropHit;

  // lowest-numbered free unit wins
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int u = 0; u < DU_COUNT; u++) begin
      if (!found && !unitBusy[u]) begin
        grant[u] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign accept  = hit && !mask;
  assign dropHit = accept && (&unitBusy);

  always_comb begin
    strobe.load  = accept ? grant : '0;
    strobe.clear = unitBusy & lastMatch;
    strobe.step  = unitBusy & stampEq & ~lastMatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unitBusy <= '0;
      expired  <= '0;
      overflow <= 1'b0;
    end else begin
      unitBusy <= (unitBusy & ~strobe.clear) | strobe.load;
      expired  <= strobe.clear;
      overflow <= overflow | dropHit;
    end
  end

  assign busy = &unitBusy;
endmodule

// File: rtl/gray_hit_delay.sv
module gray_hit_delay import ghd_pkg::*; #(
  parameter int STAMP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic                mask,
  input  logic [STAMP_W-1:0]  modulus,
  output logic [DU_COUNT-1:0] expired,
  output logic                busy,
  output logic                overflow
);
  du_strobe_t          strobe;
  logic [DU_COUNT-1:0] stampEq;
  logic [DU_COUNT-1:0] lastMatch;

  ghd_stamp_path #(.STAMP_W(STAMP_W)) i_path (
    .clk(clk), .rst(rst), .modulus(modulus), .strobe(strobe),
    .stampEq(stampEq), .lastMatch(lastMatch)
  );

  ghd_unit_ctrl i_ctrl (
    .clk(clk), .rst(rst), .hit(hit), .mask(mask),
    .stampEq(stampEq), .lastMatch(lastMatch), .strobe(strobe),
    .expired(expired), .busy(busy), .overflow(overflow)
  );
endmodule

// File: rtl/gray_hit_delay_chk.sv
module gray_hit_delay_chk (
  input logic       clk,
  input logic       rst,
  input logic       hit,
  input logic       mask,
  input logic [1:0] expired,
  input logic       busy,
  input logic       overflow
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (expired == 2'b00 && !busy && !overflow));

  // R3
  single_pulse0_chk: assert property (@(posedge clk) disable iff (rst)
    expired[0] |=> !expired[0]);

  // R3
  single_pulse1_chk: assert property (@(posedge clk) disable iff (rst)
    expired[1] |=> !expired[1]);

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R6
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(busy && hit && !mask));

  // R7
  mask_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    mask |=> $stable(overflow));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(hit && !mask));
endmodule

bind gray_hit_delay gray_hit_delay_chk i_chk (.*);

// File: tb/test_gray_hit_delay.sv
module test_gray_hit_delay;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hit = 1'b0;
  logic       mask = 1'b0;
  logic [7:0] modulus = 8'd0;
  logic [1:0] expired;
  logic       busy;
  logic       overflow;

  always #5 clk = ~clk;

  gray_hit_delay i_gray_hit_delay (
    .clk(clk), .rst(rst), .hit(hit), .mask(mask), .modulus(modulus),
    .expired(expired), .busy(busy), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;

  // reference model: a plain countdown per unit
  int       nCur = 0;
  int       rem [2];
  bit       mBusy [2];
  bit [1:0] mExp;
  bit       mOvf;

  function automatic void modelReset();
    for (int u = 0; u < 2; u++) begin
      rem[u] = 0;
      mBusy[u] = 1'b0;
    end
    mExp = 2'b00;
    mOvf = 1'b0;
  endfunction

  function automatic void modelEdge(bit h, bit m);
    bit freeB [2];
    for (int u = 0; u < 2; u++) freeB[u] = !mBusy[u];
    mExp = 2'b00;
    for (int u = 0; u < 2; u++) begin
      if (mBusy[u]) begin
        rem[u] = rem[u] - 1;
        if (rem[u] == 0) begin
          mExp[u] = 1'b1;
          mBusy[u] = 1'b0;
        end
      end
    end
    if (h && !m) begin
      if (freeB[0]) begin
        mBusy[0] = 1'b1; rem[0] = 2 * nCur + 2;
      end else if (freeB[1]) begin
        mBusy[1] = 1'b1; rem[1] = 2 * nCur + 2;
      end else begin
        mOvf = 1'b1;
      end
    end
  endfunction

  task automatic compare(string tag);
    checks++;
    if (expired !== mExp) begin
      errors++;
      $display("FAIL %s (R2 expiry, n=%0d): expired actual %b expected %b", tag, nCur, expired, mExp);
    end
    checks++;
    if (busy !== (mBusy[0] && mBusy[1])) begin
      errors++;
      $display("FAIL %s (R8 busy, n=%0d): busy actual %b expected %b", tag, nCur, busy, mBusy[0] && mBusy[1]);
    end
    checks++;
    if (overflow !== mOvf) begin
      errors++;
      $display("FAIL %s (R6 overflow, n=%0d): overflow actual %b expected %b", tag, nCur, overflow, mOvf);
    end
  endtask

  // inputs set at a falling edge, outputs compared at the next falling edge
  task automatic cyc(bit h, bit m, string tag);
    hit = h;
    mask = m;
    @(posedge clk);
    modelEdge(h, m);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int cnt, string tag);
    for (int i = 0; i < cnt; i++) cyc(1'b0, 1'b0, tag);
  endtask

  task automatic doReset(int n);
    nCur = n;
    modulus = 8'(n);
    rst = 1'b1;
    hit = 1'b0;
    mask = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    compare("R1 reset state");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nList [6] = '{0, 1, 2, 5, 12, 255};
    void'($urandom(32'd4711));
    @(negedge clk);
    foreach (nList[k]) begin
      int n = nList[k];
      // R4: first hit lands in unit 0, next one in unit 1 (R5: both held)
      doReset(n);
      cyc(1'b1, 1'b0, "R4 first hit to unit 0");
      idle(1, "R5 holding one hit");
      cyc(1'b1, 1'b0, "R5 second hit to unit 1");
      cyc(1'b1, 1'b0, "R6 hit dropped while both busy");
      cyc(1'b1, 1'b1, "R7 masked hit ignored");
      idle(2 * n + 6, "R5 both expire at own latency");
      cyc(1'b1, 1'b0, "R3 unit reusable after expiry");
      idle(2 * n + 4, "R2 latency after reuse");
      // R3: hit on the expiry edge sees unit 0 occupied, goes to unit 1
      doReset(n);
      cyc(1'b1, 1'b0, "R4 first hit to unit 0");
      idle(2 * n + 1, "R2 waiting for latency");
      cyc(1'b1, 1'b0, "R3 hit on expiry edge to unit 1");
      cyc(1'b1, 1'b0, "R3 unit 0 free on next edge");
      idle(2 * n + 4, "R2 latency of late hits");
      // R7: masked stream never occupies a unit
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "R7 masked stream");
      idle(2 * n + 4, "R7 no expiry from masked hits");
      // random traffic
      for (int i = 0; i < 3 * (2 * n + 2) + 300; i++) begin
        bit h = ($urandom % 4) == 0;
        bit m = ($urandom % 5) == 0;
        cyc(h, m, "R2 random traffic");
      end
      idle(2 * n + 4, "R2 random drain");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule